// File: doc/BRIEF.md
# Opcode-Phase Microcode Sequencer

This block is the control unit of a small microcoded processor. It holds the opcode of the instruction being executed and a 4-bit phase counter that serves as the microprogram counter. Each cycle it joins the opcode, the phase and one condition flag into a 13-bit microcode address. It looks that address up in an internal table to get a 24-bit control word, and it splits the word into the strobes that steer the datapath: ALU operand selects and function, load destination, condition-code control, address-bus source, and the counter increments.

The last step of every instruction in the table raises the opcode-load strobe. On that edge the opcode register captures the byte on the memory data bus and the phase restarts at zero, so the fetch of the next opcode overlaps the final ALU step. The table covers a small subset: add with carry in the absolute and immediate forms, push accumulator, and branch-if-minus. Any other opcode runs as a one-cycle no-op that fetches the next opcode.

Top module: `mcseq_top`

## Requirements
- R1: The microcode address is {opcode[7:0], phase[3:0], cc_flag}. Only the condition-code flag in phase 1 of the branch opcode 0x30 changes the control word, for the defined opcodes.
- R2: The control word layout, from bit 23 down to bit 0, is: ALU left select [23:22], ALU right select [21:20], ALU function [19:14], ALU drive [13], load destination [12:10], CC enable [9], CC load-not-shift [8], address source [7:6], AR increment [5], PC increment [4], SP increment [3], SP decrement [2], opcode load [1], spare [0]. Each strobe output equals its field, and the spare bit is 0. Codes: address source PC=0, AR=1, SP=2; left select A=0, X=1, PC low=2, zero=3; right select T=0, zero=1, X sign=2, A=3; function add=0x01, pass-left=0x02. SP increment and SP decrement are never both 1.
- R3: When opcode load is 0, the phase advances by one on each clock.
- R4: When opcode load is 1, on the same edge the opcode register captures mem_rdata and the phase becomes 0.
- R5: Opcode 0x6D (add with carry, absolute) runs four phases: ARLO<-mem[PC] with PC++, then ARHI<-mem[PC] with PC++, then T<-mem[AR], then A<-A+T with CC load, the next opcode fetched from mem[PC], and PC++.
- R6: Opcode 0x69 (add with carry, immediate) runs two phases: T<-mem[PC] with PC++, then the same final step as R5.
- R7: Opcode 0x48 (push A) drives A through the ALU (pass-left) into MEMORY at address SP with SP decrement in phase 0, then fetches the next opcode in phase 1.
- R8: Opcode 0x30 (branch if minus) loads T from mem[PC] with PC++ in phase 0. In phase 1, flag 0 fetches the next opcode. Flag 1 instead writes PC low + T into PCLO with CC load, and phase 2 fetches the next opcode.
- R9: Any address with no table entry gives a word whose only set fields are PC increment and opcode load (address source PC, destination T).
- R10: Reset, asynchronous and active low, sets the opcode to 0xFF and the phase to 0 at once. It is released to the state registers through two synchronizing flops. The 0xFF phase-0 word fetches an opcode from PC with PC++.
- R11: The destination codes are T=0, A=1, X=2, PCLO=3, PCHI=4, ARLO=5, ARHI=6, MEMORY=7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_rdata | input | 8 | Memory data bus, captured as the next opcode |
| cc_flag | input | 1 | Serial flag bit from the condition-code register |
| opcode | output | 8 | Current opcode register |
| phase | output | 4 | Current microcode phase |
| ctrl_word | output | 24 | Raw control word |
| alu_lsel | output | 2 | ALU left operand select |
| alu_rsel | output | 2 | ALU right operand select |
| alu_func | output | 6 | ALU function |
| alu_drive | output | 1 | ALU drives the data bus |
| ld_dest | output | 3 | Load destination |
| cc_en | output | 1 | Condition-code register enable |
| cc_load | output | 1 | Condition-code parallel load (1) or shift (0) |
| addr_src | output | 2 | Address-bus source |
| ar_inc | output | 1 | Increment AR |
| pc_inc | output | 1 | Increment PC |
| sp_inc | output | 1 | Increment SP |
| sp_dec | output | 1 | Decrement SP |
| op_load | output | 1 | Load opcode register, restart phase |

## Verification
A wrong phase or opcode shows up in the control word in the same cycle, because the table is combinational on the state registers. It also shows on the opcode and phase outputs after one edge. A missed phase restart leaves the phase past the end of an instruction, and the next cycle then shows a no-op or a wrong step where a fetch was due. A mistake in the flag path shows only in phase 1 of the branch opcode, so the stimulus drives both flag values there. A mistake in a field position shows at once as a mismatch between the raw word and the split strobes.

// File: rtl/mcseq_pkg.sv
package mcseq_pkg;
  localparam int OP_W = 8;
  localparam int PH_W = 4;
  localparam int UA_W = OP_W + PH_W + 1;
  localparam int CW_W = 24;

  typedef struct packed {
    logic [1:0] lsel;
    logic [1:0] rsel;
    logic [5:0] func;
    logic       drive;
    logic [2:0] dest;
    logic       cc_en;
    logic       cc_load;
    logic [1:0] asrc;
    logic       ar_inc;
    logic       pc_inc;
    logic       sp_inc;
    logic       sp_dec;
    logic       op_load;
    logic       spare;
  } uword_t;

  localparam logic [OP_W-1:0] OPC_BOOT    = 8'hFF;
  localparam logic [OP_W-1:0] OPC_ADC_ABS = 8'h6D;
  localparam logic [OP_W-1:0] OPC_ADC_IMM = 8'h69;
  localparam logic [OP_W-1:0] OPC_PUSH_A  = 8'h48;
  localparam logic [OP_W-1:0] OPC_BR_MI   = 8'h30;

  localparam logic [2:0] DST_T = 3'd0, DST_A = 3'd1, DST_X = 3'd2, DST_PCLO = 3'd3;
  localparam logic [2:0] DST_PCHI = 3'd4, DST_ARLO = 3'd5, DST_ARHI = 3'd6, DST_MEM = 3'd7;
  localparam logic [1:0] SRC_PC = 2'd0, SRC_AR = 2'd1, SRC_SP = 2'd2;
  localparam logic [1:0] LS_A = 2'd0, LS_X = 2'd1, LS_PCL = 2'd2, LS_ZERO = 2'd3;
  localparam logic [1:0] RS_T = 2'd0, RS_ZERO = 2'd1, RS_XSGN = 2'd2, RS_A = 2'd3;
  localparam logic [5:0] FN_ADD = 6'h01, FN_PASS = 6'h02;

  function automatic uword_t w_fetch();
    uword_t w;
    w = '0;
    w.asrc    = SRC_PC;
    w.pc_inc  = 1'b1;
    w.op_load = 1'b1;
    return w;
  endfunction

  function automatic uword_t w_mem_to(input logic [2:0] dst, input logic [1:0] src, input logic pinc);
    uword_t w;
    w = '0;
    w.dest   = dst;
    w.asrc   = src;
    w.pc_inc = pinc;
    return w;
  endfunction
endpackage

// File: rtl/mcseq_rstsync.sv
module mcseq_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/mcseq_state.sv
module mcseq_state
  import mcseq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            op_load,
  input  logic [OP_W-1:0] mem_rdata,
  input  logic            cc_flag,
  output logic [OP_W-1:0] opcode_q,
  output logic [PH_W-1:0] phase_q,
  output logic [UA_W-1:0] uaddr
);
  logic [OP_W-1:0] opcode_d;
  logic [PH_W-1:0] phase_d;
  logic            op_en;

  assign op_en = op_load;

  always_comb begin
    opcode_d = opcode_q;
    phase_d  = phase_q + {{(PH_W-1){1'b0}}, 1'b1};
    if (op_en) begin
      opcode_d = mem_rdata;
      phase_d  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opcode_q <= OPC_BOOT;
      phase_q  <= '0;
    end else begin
      opcode_q <= opcode_d;
      phase_q  <= phase_d;
    end
  end

  assign uaddr = {opcode_q, phase_q, cc_flag};
endmodule

// File: rtl/mcseq_rom.sv
module mcseq_rom
  import mcseq_pkg::*;
(
  input  logic [UA_W-1:0] uaddr,
  output uword_t          word
);
  logic [OP_W-1:0] op;
  logic [PH_W-1:0] ph;
  logic            fl;
  uword_t          add_end;
  uword_t          push_w;
  uword_t          br_w;

  assign op = uaddr[UA_W-1 -: OP_W];
  assign ph = uaddr[PH_W:1];
  assign fl = uaddr[0];

  always_comb begin
    add_end         = w_fetch();
    add_end.lsel    = LS_A;
    add_end.rsel    = RS_T;
    add_end.func    = FN_ADD;
    add_end.drive   = 1'b1;
    add_end.dest    = DST_A;
    add_end.cc_en   = 1'b1;
    add_end.cc_load = 1'b1;

    push_w          = '0;
    push_w.lsel     = LS_A;
    push_w.rsel     = RS_ZERO;
    push_w.func     = FN_PASS;
    push_w.drive    = 1'b1;
    push_w.dest     = DST_MEM;
    push_w.asrc     = SRC_SP;
    push_w.sp_dec   = 1'b1;

    br_w            = '0;
    br_w.lsel       = LS_PCL;
    br_w.rsel       = RS_T;
    br_w.func       = FN_ADD;
    br_w.drive      = 1'b1;
    br_w.dest       = DST_PCLO;
    br_w.cc_en      = 1'b1;
    br_w.cc_load    = 1'b1;
    br_w.asrc       = SRC_PC;
  end

  always_comb begin
    word = w_fetch();
    unique case (op)
      OPC_ADC_ABS: begin
        case (ph)
          4'd0:    word = w_mem_to(DST_ARLO, SRC_PC, 1'b1);
          4'd1:    word = w_mem_to(DST_ARHI, SRC_PC, 1'b1);
          4'd2:    word = w_mem_to(DST_T, SRC_AR, 1'b0);
          4'd3:    word = add_end;
          default: word = w_fetch();
        endcase
      end
      OPC_ADC_IMM: begin
        case (ph)
          4'd0:    word = w_mem_to(DST_T, SRC_PC, 1'b1);
          4'd1:    word = add_end;
          default: word = w_fetch();
        endcase
      end
      OPC_PUSH_A: begin
        if (ph == 4'd0) word = push_w;
      end
      OPC_BR_MI: begin
        case (ph)
          4'd0:    word = w_mem_to(DST_T, SRC_PC, 1'b1);
          4'd1:    word = fl ? br_w : w_fetch();
          default: word = w_fetch();
        endcase
      end
      default: word = w_fetch();
    endcase
  end
endmodule

// File: rtl/mcseq_split.sv
module mcseq_split
  import mcseq_pkg::*;
(
  input  uword_t          word,
  output logic [CW_W-1:0] ctrl_word,
  output logic [1:0]      alu_lsel,
  output logic [1:0]      alu_rsel,
  output logic [5:0]      alu_func,
  output logic            alu_drive,
  output logic [2:0]      ld_dest,
  output logic            cc_en,
  output logic            cc_load,
  output logic [1:0]      addr_src,
  output logic            ar_inc,
  output logic            pc_inc,
  output logic            sp_inc,
  output logic            sp_dec,
  output logic            op_load
);
  assign ctrl_word = word;
  assign alu_lsel  = word.lsel;
  assign alu_rsel  = word.rsel;
  assign alu_func  = word.func;
  assign alu_drive = word.drive;
  assign ld_dest   = word.dest;
  assign cc_en     = word.cc_en;
  assign cc_load   = word.cc_load;
  assign addr_src  = word.asrc;
  assign ar_inc    = word.ar_inc;
  assign pc_inc    = word.pc_inc;
  assign sp_inc    = word.sp_inc;
  assign sp_dec    = word.sp_dec;
  assign op_load   = word.op_load;
endmodule

// File: rtl/mcseq_top.sv
module mcseq_top
  import mcseq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [OP_W-1:0] mem_rdata,
  input  logic            cc_flag,
  output logic [OP_W-1:0] opcode,
  output logic [PH_W-1:0] phase,
  output logic [CW_W-1:0] ctrl_word,
  output logic [1:0]      alu_lsel,
  output logic [1:0]      alu_rsel,
  output logic [5:0]      alu_func,
  output logic            alu_drive,
  output logic [2:0]      ld_dest,
  output logic            cc_en,
  output logic            cc_load,
  output logic [1:0]      addr_src,
  output logic            ar_inc,
  output logic            pc_inc,
  output logic            sp_inc,
  output logic            sp_dec,
  output logic            op_load
);
  logic            rst_sync_n;
  logic [UA_W-1:0] uaddr;
  uword_t          word;

  mcseq_rstsync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  mcseq_state u_state (
    .clk(clk), .rst_n(rst_sync_n), .op_load(op_load), .mem_rdata(mem_rdata),
    .cc_flag(cc_flag), .opcode_q(opcode), .phase_q(phase), .uaddr(uaddr)
  );

  mcseq_rom u_rom (.uaddr(uaddr), .word(word));

  mcseq_split u_split (
    .word(word), .ctrl_word(ctrl_word), .alu_lsel(alu_lsel), .alu_rsel(alu_rsel),
    .alu_func(alu_func), .alu_drive(alu_drive), .ld_dest(ld_dest), .cc_en(cc_en),
    .cc_load(cc_load), .addr_src(addr_src), .ar_inc(ar_inc), .pc_inc(pc_inc),
    .sp_inc(sp_inc), .sp_dec(sp_dec), .op_load(op_load)
  );
endmodule

// File: rtl/mcseq_chk.sv
module mcseq_chk (
  input logic       clk,
  input logic       rst_ok,
  input logic [7:0] opcode,
  input logic [3:0] phase,
  input logic [7:0] mem_rdata,
  input logic       op_load,
  input logic       pc_inc,
  input logic       alu_drive,
  input logic [2:0] ld_dest,
  input logic       sp_inc,
  input logic       sp_dec
);
  logic defined_op;
  assign defined_op = (opcode == 8'h6D) || (opcode == 8'h69) || (opcode == 8'h48) ||
                      (opcode == 8'h30) || (opcode == 8'hFF);

  assert_phase_step_R3: assert property (@(posedge clk) disable iff (!rst_ok)
    !op_load |=> (phase == $past(phase) + 4'd1));

  assert_op_capture_R4: assert property (@(posedge clk) disable iff (!rst_ok)
    op_load |=> (phase == 4'd0 && opcode == $past(mem_rdata)));

  assert_phase_bound_R5: assert property (@(posedge clk) disable iff (!rst_ok)
    phase <= 4'd3);

  assert_adc_ends_R5: assert property (@(posedge clk) disable iff (!rst_ok)
    (opcode == 8'h6D && phase == 4'd3) |-> op_load);

  assert_sp_excl_R2: assert property (@(posedge clk) disable iff (!rst_ok)
    $onehot0({sp_inc, sp_dec}));

  assert_undef_nop_R9: assert property (@(posedge clk) disable iff (!rst_ok)
    !defined_op |-> (op_load && pc_inc && !alu_drive && ld_dest == 3'd0));
endmodule

bind mcseq_top mcseq_chk u_chk (
  .clk(clk), .rst_ok(rst_sync_n), .opcode(opcode), .phase(phase),
  .mem_rdata(mem_rdata), .op_load(op_load), .pc_inc(pc_inc), .alu_drive(alu_drive),
  .ld_dest(ld_dest), .sp_inc(sp_inc), .sp_dec(sp_dec)
);

// File: tb/mcseq_top_test.sv
module mcseq_top_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  mem_rdata;
  logic        cc_flag;
  logic [7:0]  opcode;
  logic [3:0]  phase;
  logic [23:0] ctrl_word;
  logic [1:0]  alu_lsel, alu_rsel, addr_src;
  logic [5:0]  alu_func;
  logic [2:0]  ld_dest;
  logic        alu_drive, cc_en, cc_load, ar_inc, pc_inc, sp_inc, sp_dec, op_load;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  mcseq_top uut (
    .clk(clk), .rst_n(rst_n), .mem_rdata(mem_rdata), .cc_flag(cc_flag),
    .opcode(opcode), .phase(phase), .ctrl_word(ctrl_word), .alu_lsel(alu_lsel),
    .alu_rsel(alu_rsel), .alu_func(alu_func), .alu_drive(alu_drive), .ld_dest(ld_dest),
    .cc_en(cc_en), .cc_load(cc_load), .addr_src(addr_src), .ar_inc(ar_inc),
    .pc_inc(pc_inc), .sp_inc(sp_inc), .sp_dec(sp_dec), .op_load(op_load)
  );

  always #10 clk = ~clk;

  // field packer: lsel rsel func drive dest ccen ccld asrc arinc pcinc spinc spdec opld
  function automatic logic [23:0] mk(input logic [1:0] ls, input logic [1:0] rs,
      input logic [5:0] fn, input logic dr, input logic [2:0] ds, input logic ce,
      input logic cl, input logic [1:0] as, input logic ai, input logic pi,
      input logic si, input logic sd, input logic ol);
    return {ls, rs, fn, dr, ds, ce, cl, as, ai, pi, si, sd, ol, 1'b0};
  endfunction

  function automatic logic [23:0] exp_word(input logic [7:0] op, input logic [3:0] ph,
                                           input logic fl);
    logic [23:0] fetch, addw;
    fetch = mk(2'd0, 2'd0, 6'h00, 0, 3'd0, 0, 0, 2'd0, 0, 1, 0, 0, 1);
    addw  = mk(2'd0, 2'd0, 6'h01, 1, 3'd1, 1, 1, 2'd0, 0, 1, 0, 0, 1);
    case (op)
      8'h6D: case (ph)
        4'd0: return mk(0, 0, 0, 0, 3'd5, 0, 0, 2'd0, 0, 1, 0, 0, 0);
        4'd1: return mk(0, 0, 0, 0, 3'd6, 0, 0, 2'd0, 0, 1, 0, 0, 0);
        4'd2: return mk(0, 0, 0, 0, 3'd0, 0, 0, 2'd1, 0, 0, 0, 0, 0);
        4'd3: return addw;
        default: return fetch;
      endcase
      8'h69: case (ph)
        4'd0: return mk(0, 0, 0, 0, 3'd0, 0, 0, 2'd0, 0, 1, 0, 0, 0);
        4'd1: return addw;
        default: return fetch;
      endcase
      8'h48: return (ph == 4'd0) ? mk(2'd0, 2'd1, 6'h02, 1, 3'd7, 0, 0, 2'd2, 0, 0, 0, 1, 0)
                                 : fetch;
      8'h30: case (ph)
        4'd0: return mk(0, 0, 0, 0, 3'd0, 0, 0, 2'd0, 0, 1, 0, 0, 0);
        4'd1: return fl ? mk(2'd2, 2'd0, 6'h01, 1, 3'd3, 1, 1, 2'd0, 0, 0, 0, 0, 0) : fetch;
        default: return fetch;
      endcase
      default: return fetch;
    endcase
  endfunction

  function automatic string tag_of(input logic [7:0] op, input logic [3:0] ph);
    case (op)
      8'h6D: return "R5";
      8'h69: return "R6";
      8'h48: return "R7";
      8'h30: return (ph == 4'd1) ? "R8/R1" : "R8";
      8'hFF: return "R10";
      default: return "R9";
    endcase
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  logic [7:0] m_op;
  logic [3:0] m_ph;

  task automatic check_cycle();
    logic [23:0] e;
    string t;
    e = exp_word(m_op, m_ph, cc_flag);
    t = tag_of(m_op, m_ph);
    chk("R3/R4", "opcode", {24'd0, opcode}, {24'd0, m_op});
    chk("R3/R4", "phase", {28'd0, phase}, {28'd0, m_ph});
    chk(t, "ctrl_word", {8'd0, ctrl_word}, {8'd0, e});
    // R2 layout and R11 destination field at the split ports
    chk("R2", "split", {8'd0, alu_lsel, alu_rsel, alu_func, alu_drive, ld_dest, cc_en,
        cc_load, addr_src, ar_inc, pc_inc, sp_inc, sp_dec, op_load, 1'b0}, {8'd0, e});
    chk("R11", "ld_dest", {29'd0, ld_dest}, {29'd0, e[12:10]});
  endtask

  task automatic step(input logic [7:0] d, input logic f);
    logic [23:0] e;
    mem_rdata = d;
    cc_flag   = f;
    #1;
    check_cycle();
    e = exp_word(m_op, m_ph, f);
    if (e[1]) begin m_op = d; m_ph = 4'd0; end
    else      m_ph = m_ph + 4'd1;
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R10", "async opcode", {24'd0, opcode}, 32'h0000_00FF);
    chk("R10", "async phase", {28'd0, phase}, 32'd0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    m_op = 8'hFF;
    m_ph = 4'd0;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    mem_rdata = 8'h00;
    cc_flag   = 1'b0;
    #1;
    chk("R10", "boot word", {8'd0, ctrl_word}, {8'd0, exp_word(8'hFF, 4'd0, 1'b0)});
  endtask

  initial begin
    int unsigned seed;
    logic [7:0] pick;
    seed = $urandom(32'h5EC0_0D17);
    rst_n = 1'b1;
    mem_rdata = 8'h00;
    cc_flag = 1'b0;
    m_op = 8'hFF;
    m_ph = 4'd0;
    do_reset();
    // directed: full R5 sequence, R6, R7, R8 both flags, undefined R9
    step(8'h6D, 0); step(8'h11, 1); step(8'h22, 0); step(8'h33, 1);
    step(8'h69, 0); step(8'h44, 0); step(8'h48, 1); step(8'h55, 0);
    step(8'h30, 0); step(8'h66, 0); step(8'h30, 0); step(8'h77, 0);
    step(8'h30, 1); step(8'h88, 1); step(8'h99, 0); step(8'h13, 1);
    step(8'h00, 0); step(8'hFF, 1); step(8'h6D, 1);
    for (int i = 0; i < 1500; i++) begin
      case ($urandom % 6)
        0: pick = 8'h6D;
        1: pick = 8'h69;
        2: pick = 8'h48;
        3: pick = 8'h30;
        default: pick = 8'($urandom);
      endcase
      step(pick, 1'($urandom));
      if (i == 700) do_reset();
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule